// File: doc/BRIEF.md
# Instruction Fetch Next-PC Unit

This block owns the 32-bit program counter of a fetch stage and chooses, every clock cycle, the address the counter moves to. The choice is made from the instruction word currently being fetched: ordinary instructions advance to the following word, two compare-and-branch forms move by a signed instruction count measured from the following word, two absolute jump forms replace the low 28 address bits while keeping the current 256 MB region, and a register jump loads an arbitrary 32-bit address supplied by the register file.

The surrounding pipeline supplies the instruction word, the two operand values for the branch compare and the register-jump target, and may freeze the counter with a stall input. The block returns the current counter, the address it will take at the next unstalled edge, and the return address plus a write strobe for the call form of the jump. All pins are plain control and data; there is no handshake, so the stall input is the only back-pressure, and it holds the counter rather than queueing anything.

Top module: `pcf_next_pc`

## Requirements
- R1: A synchronous active-high reset loads the counter with the RESET_VEC parameter (default 0x00000000).
- R2: While stall is high the counter keeps its value across the clock edge; next_pc still shows the computed next address.
- R3: Any instruction that is not a branch, jump or register jump (opcode is instr[31:26]) gives next_pc = pc + 4.
- R4: Opcode 4 (branch-if-equal) with rs_val == rt_val gives next_pc = pc + 4 + (sign-extended instr[15:0] << 2); with unequal operands it gives pc + 4. Encoding opcode 4, rs 9, rt 0, immediate 3 lands 16 bytes past the branch.
- R5: Opcode 5 (branch-if-not-equal) takes the same target when rs_val != rt_val and gives pc + 4 when they are equal.
- R6: Opcode 2 (jump) gives next_pc = {pc[31:28], instr[25:0], 2'b00}; the top four bits always come from the current counter.
- R7: Opcode 3 (jump-and-link) takes the R6 target and raises link_we while stall is low.
- R8: Opcode 0 with funct instr[5:0] = 0x08 gives next_pc = jr_target unchanged in all 32 bits; opcode 0 with any other funct follows R3.
- R9: On every edge with reset and stall low the counter takes the value next_pc had before that edge.
- R10: link_addr always equals pc + 4, and link_we is low for every instruction other than opcode 3 and whenever stall is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| stall | input | 1 | Holds the counter when high |
| instr | input | 32 | Instruction word at the current counter |
| rs_val | input | 32 | First branch compare operand |
| rt_val | input | 32 | Second branch compare operand |
| jr_target | input | 32 | Register-jump destination |
| pc | output | 32 | Current counter value |
| next_pc | output | 32 | Address taken at the next unstalled edge |
| link_addr | output | 32 | Return address for the call form |
| link_we | output | 1 | Return-address write strobe |

## Verification
A stall can coincide with a taken branch or with a jump-and-link in the same cycle, and these are the interactions that matter: the counter must freeze while next_pc still shows the redirected target, and the link strobe must drop even though the call is decoded. The bench drives a stalled jump-and-link and a stalled taken branch, checks that pc held, that next_pc carried the target and link_we was low, and then releases the stall to confirm the same instruction redirects on the following edge. Branch immediates are swept over the sign boundary for both compare senses and both operand relations, and jumps are placed on either side of a 256 MB boundary.

// File: rtl/pcf_pkg.sv
package pcf_pkg;
  localparam logic [5:0] OP_SPECIAL = 6'd0;
  localparam logic [5:0] OP_JUMP    = 6'd2;
  localparam logic [5:0] OP_CALL    = 6'd3;
  localparam logic [5:0] OP_BR_EQ   = 6'd4;
  localparam logic [5:0] OP_BR_NE   = 6'd5;
  localparam logic [5:0] FN_REGJMP  = 6'h08;

  typedef enum logic [2:0] {
    FLOW_SEQ,
    FLOW_BR_EQ,
    FLOW_BR_NE,
    FLOW_ABS,
    FLOW_REG
  } flow_e;
endpackage

// File: rtl/pcf_decode.sv
module pcf_decode
  import pcf_pkg::*;
#(
  parameter int INSN_W = 32
) (
  input  logic [INSN_W-1:0] instr,
  output flow_e             kind,
  output logic              is_call
);
  localparam int OP_LSB = INSN_W - 6;

  logic [5:0] opc;
  logic [5:0] fn;

  assign opc = instr[INSN_W-1:OP_LSB];
  assign fn  = instr[5:0];

  always_comb begin
    kind    = FLOW_SEQ;
    is_call = 1'b0;
    case (opc)
      OP_BR_EQ: kind = FLOW_BR_EQ;
      OP_BR_NE: kind = FLOW_BR_NE;
      OP_JUMP:  kind = FLOW_ABS;
      OP_CALL: begin
        kind    = FLOW_ABS;
        is_call = 1'b1;
      end
      OP_SPECIAL: if (fn == FN_REGJMP) kind = FLOW_REG;
      default:  kind = FLOW_SEQ;
    endcase
  end
endmodule

// File: rtl/pcf_targets.sv
module pcf_targets #(
  parameter int PC_W    = 32,
  parameter int INSN_W  = 32,
  parameter int IMM_W   = 16,
  parameter int FIELD_W = 26
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [INSN_W-1:0] instr,
  output logic [PC_W-1:0]   seq_pc,
  output logic [PC_W-1:0]   br_pc,
  output logic [PC_W-1:0]   abs_pc
);
  localparam int REGION_W = PC_W - FIELD_W - 2;
  localparam int EXT_W    = PC_W - IMM_W - 2;
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  logic [PC_W-1:0] offs;

  assign seq_pc = pc + STEP;
  assign offs   = {{EXT_W{instr[IMM_W-1]}}, instr[IMM_W-1:0], 2'b00};
  assign br_pc  = seq_pc + offs;
  assign abs_pc = {pc[PC_W-1 -: REGION_W], instr[FIELD_W-1:0], 2'b00};
endmodule

// File: rtl/pcf_select.sv
module pcf_select
  import pcf_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int DATA_W = 32
) (
  input  flow_e             kind,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  input  logic [PC_W-1:0]   seq_pc,
  input  logic [PC_W-1:0]   br_pc,
  input  logic [PC_W-1:0]   abs_pc,
  input  logic [PC_W-1:0]   jr_target,
  output logic [PC_W-1:0]   next_pc
);
  logic same;

  assign same = (rs_val == rt_val);

  always_comb begin
    case (kind)
      FLOW_BR_EQ: next_pc = same ? br_pc : seq_pc;
      FLOW_BR_NE: next_pc = same ? seq_pc : br_pc;
      FLOW_ABS:   next_pc = abs_pc;
      FLOW_REG:   next_pc = jr_target;
      default:    next_pc = seq_pc;
    endcase
  end
endmodule

// File: rtl/pcf_next_pc.sv
module pcf_next_pc
  import pcf_pkg::*;
#(
  parameter int              PC_W      = 32,
  parameter int              DATA_W    = 32,
  parameter logic [PC_W-1:0] RESET_VEC = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              stall,
  input  logic [31:0]       instr,
  input  logic [DATA_W-1:0] rs_val,
  input  logic [DATA_W-1:0] rt_val,
  input  logic [PC_W-1:0]   jr_target,
  output logic [PC_W-1:0]   pc,
  output logic [PC_W-1:0]   next_pc,
  output logic [PC_W-1:0]   link_addr,
  output logic              link_we
);
  flow_e           kind;
  logic            is_call;
  logic [PC_W-1:0] seq_pc, br_pc, abs_pc;

  pcf_decode #(.INSN_W(32)) u_dec (
    .instr   (instr),
    .kind    (kind),
    .is_call (is_call)
  );

  pcf_targets #(.PC_W(PC_W), .INSN_W(32), .IMM_W(16), .FIELD_W(26)) u_tgt (
    .pc     (pc),
    .instr  (instr),
    .seq_pc (seq_pc),
    .br_pc  (br_pc),
    .abs_pc (abs_pc)
  );

  pcf_select #(.PC_W(PC_W), .DATA_W(DATA_W)) u_sel (
    .kind      (kind),
    .rs_val    (rs_val),
    .rt_val    (rt_val),
    .seq_pc    (seq_pc),
    .br_pc     (br_pc),
    .abs_pc    (abs_pc),
    .jr_target (jr_target),
    .next_pc   (next_pc)
  );

  always_ff @(posedge clk) begin
    if (rst)         pc <= RESET_VEC;
    else if (!stall) pc <= next_pc;
  end

  assign link_addr = seq_pc;
  assign link_we   = is_call & ~stall;
endmodule

// File: rtl/pcf_next_pc_chk.sv
module pcf_next_pc_chk #(
  parameter int              PC_W      = 32,
  parameter int              DATA_W    = 32,
  parameter logic [PC_W-1:0] RESET_VEC = '0
) (
  input logic              clk,
  input logic              rst,
  input logic              stall,
  input logic [31:0]       instr,
  input logic [DATA_W-1:0] rs_val,
  input logic [DATA_W-1:0] rt_val,
  input logic [PC_W-1:0]   pc,
  input logic [PC_W-1:0]   next_pc,
  input logic              link_we
);
  localparam int REGION_W = PC_W - 28;
  localparam logic [PC_W-1:0] STEP = PC_W'(4);

  a_r1_reset_vec: assert property (@(posedge clk) rst |=> pc == RESET_VEC);

  a_r2_stall_hold: assert property (@(posedge clk) disable iff (rst)
    stall |=> $stable(pc));

  a_r9_advance: assert property (@(posedge clk) disable iff (rst)
    !stall |=> pc == $past(next_pc));

  a_r4_beq_fall: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'd4 && rs_val != rt_val) |-> next_pc == pc + STEP);

  a_r5_bne_fall: assert property (@(posedge clk) disable iff (rst)
    (instr[31:26] == 6'd5 && rs_val == rt_val) |-> next_pc == pc + STEP);

  a_r6_region: assert property (@(posedge clk) disable iff (rst)
    (!stall && instr[31:27] == 5'b00001) |=>
      pc[PC_W-1 -: REGION_W] == $past(pc[PC_W-1 -: REGION_W]));

  a_r10_link_strobe: assert property (@(posedge clk) disable iff (rst)
    link_we |-> (instr[31:26] == 6'd3 && !stall));
endmodule

bind pcf_next_pc pcf_next_pc_chk #(
  .PC_W(PC_W), .DATA_W(DATA_W), .RESET_VEC(RESET_VEC)
) u_chk (
  .clk(clk), .rst(rst), .stall(stall), .instr(instr),
  .rs_val(rs_val), .rt_val(rt_val), .pc(pc),
  .next_pc(next_pc), .link_we(link_we)
);

// File: tb/pcf_next_pc_bench.sv
module pcf_next_pc_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        stall = 1'b0;
  logic [31:0] instr = '0, rs_val = '0, rt_val = '0, jr_target = '0;
  logic [31:0] pc, next_pc, link_addr;
  logic        link_we;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [31:0] exp_pc;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcf_next_pc u_pcf_next_pc (
    .clk(clk), .rst(rst), .stall(stall), .instr(instr),
    .rs_val(rs_val), .rt_val(rt_val), .jr_target(jr_target),
    .pc(pc), .next_pc(next_pc), .link_addr(link_addr), .link_we(link_we)
  );

  function automatic logic [31:0] mk_i(input logic [5:0] op, input logic [4:0] rs,
                                       input logic [4:0] rt, input logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] mk_j(input logic [5:0] op, input logic [25:0] f);
    return {op, f};
  endfunction

  function automatic logic [31:0] mk_r(input logic [5:0] fn);
    return {6'd0, 5'd31, 15'd0, fn};
  endfunction

  function automatic logic [31:0] ref_next(input logic [31:0] p, input logic [31:0] ins,
                                           input logic [31:0] a, input logic [31:0] b,
                                           input logic [31:0] jt);
    logic [31:0] s, t;
    s = p + 32'd4;
    t = s + {{14{ins[15]}}, ins[15:0], 2'b00};
    case (ins[31:26])
      6'd4:    return (a == b) ? t : s;
      6'd5:    return (a != b) ? t : s;
      6'd2,
      6'd3:    return {p[31:28], ins[25:0], 2'b00};
      6'd0:    return (ins[5:0] == 6'h08) ? jt : s;
      default: return s;
    endcase
  endfunction

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic step(input logic [31:0] ins, input logic [31:0] a, input logic [31:0] b,
                      input logic [31:0] jt, input logic st, input string req);
    logic [31:0] en;
    @(negedge clk);
    instr = ins; rs_val = a; rt_val = b; jr_target = jt; stall = st;
    #1;
    en = ref_next(exp_pc, ins, a, b, jt);
    check(next_pc, en, req);
    check(link_addr, exp_pc + 32'd4, "R10");
    check({31'd0, link_we}, {31'd0, (ins[31:26] == 6'd3) && !st},
          (ins[31:26] == 6'd3) ? "R7" : "R10");
    @(posedge clk);
    #1;
    if (!st) exp_pc = en;
    check(pc, exp_pc, st ? "R2" : "R9");
  endtask

  task automatic go_to(input logic [31:0] addr);
    step(mk_r(6'h08), 0, 0, addr, 1'b0, "R8");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; stall = 1'b0;
    @(posedge clk); #1;
    rst = 1'b0;
    exp_pc = 32'h0;
    check(pc, 32'h0, "R1");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] imms [8];
    imms = '{16'h0000, 16'h0001, 16'h0003, 16'hFFFF, 16'hFFFE,
             16'h7FFF, 16'h8000, 16'h1234};
    exp_pc = 32'h0;
    repeat (2) @(posedge clk);
    do_reset();

    // R3: plain flow, including other opcode-0 functs and arithmetic opcodes
    step(32'h0000_0000, 0, 0, 32'hFFFF_FFF0, 1'b0, "R3");
    step(mk_i(6'd8, 5'd1, 5'd2, 16'hFFFF), 0, 0, 0, 1'b0, "R3");
    step(mk_r(6'h20), 0, 0, 32'h1111_1110, 1'b0, "R8");
    step(mk_i(6'd43, 5'd3, 5'd4, 16'h0010), 0, 0, 0, 1'b0, "R3");

    // R4: worked encoding opcode 4, rs 9, rt 0, imm 3
    go_to(32'h0040_0000);
    step(mk_i(6'd4, 5'd9, 5'd0, 16'd3), 32'd5, 32'd5, 0, 1'b0, "R4");
    check(pc, 32'h0040_0010, "R4");

    // R4/R5 sweep: both senses, both relations, immediates across the sign boundary
    for (int op = 4; op <= 5; op++)
      for (int eq = 0; eq < 2; eq++)
        for (int k = 0; k < 8; k++) begin
          go_to(32'h0080_0000);
          step(mk_i(6'(op), 5'd1, 5'd2, imms[k]), 32'hA5A5_0000,
               eq ? 32'hA5A5_0000 : 32'hA5A5_0001, 0, 1'b0, op == 4 ? "R4" : "R5");
        end

    // R6/R7: jumps either side of a 256 MB boundary
    go_to(32'h1FFF_FFF8);
    step(32'h0, 0, 0, 0, 1'b0, "R3");
    step(mk_j(6'd2, 26'h3FF_FFFF), 0, 0, 0, 1'b0, "R6");
    check(pc, 32'h1FFF_FFFC, "R6");
    step(32'h0, 0, 0, 0, 1'b0, "R3");
    check(pc, 32'h2000_0000, "R3");
    step(mk_j(6'd2, 26'h000_0010), 0, 0, 0, 1'b0, "R6");
    check(pc, 32'h2000_0040, "R6");
    step(mk_j(6'd3, 26'h155_5555), 0, 0, 0, 1'b0, "R7");
    check(pc, 32'h2555_5554, "R7");

    // R2: stall coinciding with jump-and-link and with a taken branch
    step(mk_j(6'd3, 26'h000_0100), 0, 0, 0, 1'b1, "R2");
    step(mk_j(6'd3, 26'h000_0100), 0, 0, 0, 1'b0, "R7");
    step(mk_i(6'd5, 5'd1, 5'd2, 16'hFFF0), 1, 2, 0, 1'b1, "R2");
    step(mk_i(6'd5, 5'd1, 5'd2, 16'hFFF0), 1, 2, 0, 1'b1, "R2");
    step(mk_i(6'd5, 5'd1, 5'd2, 16'hFFF0), 1, 2, 0, 1'b0, "R5");

    // R8: register jumps to arbitrary addresses
    go_to(32'hDEAD_BEEC);
    check(pc, 32'hDEAD_BEEC, "R8");
    go_to(32'h1234_5678);
    check(pc, 32'h1234_5678, "R8");

    // R1: reset mid-run
    do_reset();
    step(32'h0, 0, 0, 0, 1'b0, "R3");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule